// File: doc/BRIEF.md
# Serial Frame Sync Generator

This block produces the transmit frame-sync strobe for a synchronous serial port. A bit clock is taken from one of two sources. It is counted into words of a fixed number of bits, and the words are counted again into frames. The frame length is set by a small programmable rate field. The strobe can take one of two shapes: high for exactly the first bit of a frame, or high for the whole first word of a frame.

The block also decides which framing signal the transmitter really uses. The choices are the receive-side frame sync, the strobe generated here, or a level arriving on a shared pin. When the internal strobe is the chosen source, the block also asks for that strobe to be driven out on the shared pin. The pin driver itself lives outside the block.

The counters restart cleanly whenever generation is disabled or the clock choice, pulse shape or rate field changes. A new frame therefore always begins on a predictable bit.

Top module: `frame_sync_gen`

## Requirements
- R1: When `clk_src_mode` equals 2'b10 the counters advance on rising edges of `tx_clk_pin`; for every other value they advance on rising edges of `rx_clk`.
- R2: While `rst_n` is low, `int_fsync` is 0 and all counters are cleared.
- R3: A rising bit-clock edge that samples `enable` low clears the counters, and `int_fsync` is 0 during the following bit period.
- R4: A bit-clock edge that samples `enable` high, with the control fields unchanged since the previous edge, after a cleared state starts a frame: `int_fsync` is high during the bit period following the next edge, which is bit 0 of frame word 0.
- R5: With `word_wide` = 0, `int_fsync` is high for exactly one bit period per frame, and frames repeat every WORD_LEN*(rate_sel+1) bit periods (WORD_LEN = 16 by default).
- R6: With `word_wide` = 1, `int_fsync` is high for WORD_LEN consecutive bit periods at the start of each frame and low for the remaining WORD_LEN*rate_sel bit periods.
- R7: `rate_sel` = 0 produces a frame on every word.
- R8: A bit-clock edge that samples `rate_sel`, `word_wide` or `clk_src_mode` different from their values at the previous edge clears the counters, and `int_fsync` is 0 for the following bit period. Counting then restarts as in R4.
- R9: `tx_fsync` follows `rx_fsync` when `frame_src_mode` is 2'b00 or 2'b01, follows `int_fsync` when it is 2'b10, and follows `io2_pin_in` when it is 2'b11, combinationally.
- R10: `io2_drive_en` is 1 exactly when `frame_src_mode` is 2'b10, and `io2_drive_val` always equals `int_fsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous generation enable, sampled on the bit clock |
| clk_src_mode | input | 2 | Clock source mode; 2'b10 picks the transmit clock pin |
| frame_src_mode | input | 2 | Framing source mode for the transmitter |
| rate_sel | input | RATE_W | Frame-rate factor; frames are rate_sel+1 words long |
| word_wide | input | 1 | 0: one-bit-wide strobe, 1: one-word-wide strobe |
| tx_clk_pin | input | 1 | Transmit clock from its pin |
| rx_clk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive-side frame sync |
| io2_pin_in | input | 1 | Level arriving on the shared framing pin |
| int_fsync | output | 1 | Internally generated frame sync |
| tx_fsync | output | 1 | Framing signal used by the transmitter |
| io2_drive_en | output | 1 | Request to drive the shared pin |
| io2_drive_val | output | 1 | Value to drive on the shared pin |

## Verification
The assertions check the following on every bit-clock edge:
- a disabled edge or a change in the control fields is followed by a low strobe;
- a one-bit strobe never lasts two bit periods;
- the framing-source selection and the pin-drive request match the mode.

The frame period, the width of a word-wide strobe, the first frame after enable and the choice of clock can only be shown by the bench. It counts strobe rises, high periods and elapsed time over whole frames, and it compares every bit period against a behavioural counter model.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

   typedef enum logic [1:0] {
      SRC_RX_A = 2'b00,
      SRC_RX_B = 2'b01,
      SRC_INT  = 2'b10,
      SRC_PIN  = 2'b11
   } frame_src_e;

   localparam logic [1:0] CLK_SEL_TX = 2'b10;

endpackage

// File: rtl/fsg_ctl.sv
module fsg_ctl #(
   parameter int RATE_W = 4
) (
   input  logic              bit_clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        clk_src_mode,
   input  logic              word_wide,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              clear,
   output logic              advance,
   output logic              shape_q,
   output logic [RATE_W-1:0] rate_q
);

   localparam int CFG_W = RATE_W + 3;

   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;
   logic             run_q;
   logic             cfg_moved;

   assign cfg_now   = {clk_src_mode, word_wide, rate_sel};
   assign cfg_moved = (cfg_now != cfg_q);
   assign clear     = !enable || cfg_moved;
   assign advance   = run_q && !clear;
   assign shape_q   = cfg_q[RATE_W];
   assign rate_q    = cfg_q[RATE_W-1:0];

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         run_q <= 1'b0;
      end else begin
         cfg_q <= cfg_now;
         run_q <= !clear;
      end
   end

   // run flag must be exposed to the pulse shaper through advance/clear only
endmodule

// File: rtl/fsg_word_div.sv
module fsg_word_div #(
   parameter int WORD_LEN = 16
) (
   input  logic                         bit_clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         advance,
   output logic [$clog2(WORD_LEN)-1:0]  bit_idx,
   output logic                         word_last
);

   localparam int IDX_W = $clog2(WORD_LEN);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_LEN - 1);
   localparam bit POW2 = (WORD_LEN == (1 << IDX_W));

   assign word_last = (bit_idx == LAST_IDX);

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge bit_clk or negedge rst_n) begin
            if (!rst_n)
               bit_idx <= '0;
            else if (clear)
               bit_idx <= '0;
            else if (advance)
               bit_idx <= bit_idx + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge bit_clk or negedge rst_n) begin
            if (!rst_n)
               bit_idx <= '0;
            else if (clear)
               bit_idx <= '0;
            else if (advance)
               bit_idx <= word_last ? '0 : bit_idx + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/fsg_frame_div.sv
module fsg_frame_div #(
   parameter int RATE_W = 4
) (
   input  logic              bit_clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [RATE_W-1:0] rate_q,
   output logic              frame_first
);

   logic [RATE_W-1:0] word_idx;

   assign frame_first = (word_idx == '0);

   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n)
         word_idx <= '0;
      else if (clear)
         word_idx <= '0;
      else if (step)
         word_idx <= (word_idx >= rate_q) ? '0 : word_idx + 1'b1;
   end

endmodule

// File: rtl/fsg_route.sv
module fsg_route
   import fsg_pkg::*;
(
   input  logic       running,
   input  logic       frame_first,
   input  logic       word_first,
   input  logic       shape_q,
   input  logic [1:0] frame_src_mode,
   input  logic       rx_fsync,
   input  logic       io2_pin_in,
   output logic       int_fsync,
   output logic       tx_fsync,
   output logic       io2_drive_en,
   output logic       io2_drive_val
);

   frame_src_e src;

   assign src           = frame_src_e'(frame_src_mode);
   assign int_fsync     = running && frame_first && (shape_q || word_first);
   assign io2_drive_en  = (src == SRC_INT);
   assign io2_drive_val = int_fsync;

   always_comb begin
      unique case (src)
         SRC_RX_A, SRC_RX_B: tx_fsync = rx_fsync;
         SRC_INT:            tx_fsync = int_fsync;
         SRC_PIN:            tx_fsync = io2_pin_in;
         default:            tx_fsync = rx_fsync;
      endcase
   end

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
   import fsg_pkg::*;
#(
   parameter int WORD_LEN = 16,
   parameter int RATE_W   = 4
) (
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        clk_src_mode,
   input  logic [1:0]        frame_src_mode,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              word_wide,
   input  logic              tx_clk_pin,
   input  logic              rx_clk,
   input  logic              rx_fsync,
   input  logic              io2_pin_in,
   output logic              int_fsync,
   output logic              tx_fsync,
   output logic              io2_drive_en,
   output logic              io2_drive_val
);

   localparam int IDX_W = $clog2(WORD_LEN);

   generate
      if (WORD_LEN < 2) begin : g_bad_word
         $error("frame_sync_gen: WORD_LEN must be at least 2");
      end
      if (RATE_W < 1) begin : g_bad_rate
         $error("frame_sync_gen: RATE_W must be at least 1");
      end
   endgenerate

   logic              bit_clk;
   logic              clear;
   logic              advance;
   logic              shape_q;
   logic [RATE_W-1:0] rate_q;
   logic [IDX_W-1:0]  bit_idx;
   logic              word_last;
   logic              frame_first;
   logic              running;

   assign bit_clk = (clk_src_mode == CLK_SEL_TX) ? tx_clk_pin : rx_clk;

   fsg_ctl #(.RATE_W(RATE_W)) u_ctl (
      .bit_clk      (bit_clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .clk_src_mode (clk_src_mode),
      .word_wide    (word_wide),
      .rate_sel     (rate_sel),
      .clear        (clear),
      .advance      (advance),
      .shape_q      (shape_q),
      .rate_q       (rate_q)
   );

   // running: the control block released the counters at the last edge
   logic run_seen_q;
   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n)
         run_seen_q <= 1'b0;
      else
         run_seen_q <= !clear;
   end
   assign running = run_seen_q;

   fsg_word_div #(.WORD_LEN(WORD_LEN)) u_word (
      .bit_clk   (bit_clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .advance   (advance),
      .bit_idx   (bit_idx),
      .word_last (word_last)
   );

   fsg_frame_div #(.RATE_W(RATE_W)) u_frame (
      .bit_clk     (bit_clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .step        (advance && word_last),
      .rate_q      (rate_q),
      .frame_first (frame_first)
   );

   fsg_route u_route (
      .running        (running),
      .frame_first    (frame_first),
      .word_first     (bit_idx == '0),
      .shape_q        (shape_q),
      .frame_src_mode (frame_src_mode),
      .rx_fsync       (rx_fsync),
      .io2_pin_in     (io2_pin_in),
      .int_fsync      (int_fsync),
      .tx_fsync       (tx_fsync),
      .io2_drive_en   (io2_drive_en),
      .io2_drive_val  (io2_drive_val)
   );

endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
   parameter int RATE_W = 4
) (
   input logic              bit_clk,
   input logic              rst_n,
   input logic              enable,
   input logic [1:0]        clk_src_mode,
   input logic [1:0]        frame_src_mode,
   input logic [RATE_W-1:0] rate_sel,
   input logic              word_wide,
   input logic              rx_fsync,
   input logic              io2_pin_in,
   input logic              int_fsync,
   input logic              tx_fsync,
   input logic              io2_drive_en,
   input logic              io2_drive_val
);

   logic seen_q;
   always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n)
         seen_q <= 1'b0;
      else
         seen_q <= 1'b1;
   end

   // R3
   disabled_low_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !enable |=> !int_fsync);

   // R8
   rate_restart_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (seen_q && !$stable(rate_sel)) |=> !int_fsync);

   // R8
   shape_restart_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (seen_q && !$stable(word_wide)) |=> !int_fsync);

   // R5
   bit_pulse_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (seen_q && !word_wide && $stable(word_wide) && int_fsync) |=> !int_fsync);

   // R9
   rx_src_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (frame_src_mode[1] == 1'b0) |-> (tx_fsync == rx_fsync));

   // R9
   pin_src_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (frame_src_mode == 2'b11) |-> (tx_fsync == io2_pin_in));

   // R10
   drive_req_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      (io2_drive_en == (frame_src_mode == 2'b10)) && (io2_drive_val == int_fsync));

   // R1
   clk_mode_known_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      !$isunknown(clk_src_mode));

endmodule

bind frame_sync_gen fsg_chk #(.RATE_W(RATE_W)) u_chk (
   .bit_clk        (bit_clk),
   .rst_n          (rst_n),
   .enable         (enable),
   .clk_src_mode   (clk_src_mode),
   .frame_src_mode (frame_src_mode),
   .rate_sel       (rate_sel),
   .word_wide      (word_wide),
   .rx_fsync       (rx_fsync),
   .io2_pin_in     (io2_pin_in),
   .int_fsync      (int_fsync),
   .tx_fsync       (tx_fsync),
   .io2_drive_en   (io2_drive_en),
   .io2_drive_val  (io2_drive_val)
);

// File: tb/tb_frame_sync_gen.sv
`timescale 1ns/1ps
module tb_frame_sync_gen;

   localparam int WLEN = 16;

   logic rx_clk = 1'b0;
   logic tx_clk = 1'b0;
   always #2 rx_clk = ~rx_clk;
   initial begin
      #0.5;
      forever #3 tx_clk = ~tx_clk;
   end

   logic       rst_n = 1'b1;
   logic       enable = 1'b0;
   logic [1:0] clk_src_mode = 2'b00;
   logic [1:0] frame_src_mode = 2'b00;
   logic [3:0] rate_sel = 4'd0;
   logic       word_wide = 1'b0;
   logic       rx_fsync = 1'b0;
   logic       io2_pin_in = 1'b0;
   logic       int_fsync, tx_fsync, io2_drive_en, io2_drive_val;

   frame_sync_gen dut (
      .rst_n(rst_n), .enable(enable), .clk_src_mode(clk_src_mode),
      .frame_src_mode(frame_src_mode), .rate_sel(rate_sel), .word_wide(word_wide),
      .tx_clk_pin(tx_clk), .rx_clk(rx_clk), .rx_fsync(rx_fsync), .io2_pin_in(io2_pin_in),
      .int_fsync(int_fsync), .tx_fsync(tx_fsync), .io2_drive_en(io2_drive_en),
      .io2_drive_val(io2_drive_val));

   // R1: the model's own choice of bit clock
   wire m_clk = (clk_src_mode == 2'b10) ? tx_clk : rx_clk;

   int    checks = 0;
   int    fails = 0;
   bit    done = 0;
   string cur_req = "R2";

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int        m_bit, m_word;
   bit        m_run;
   int        m_rate;
   bit        m_shape;
   int        m_clkmode;
   bit        chg;
   bit        exp_int, exp_tx;
   int        meas_left = 0, meas_total = 0, rises = 0, highs = 0;
   bit        prev = 0;
   realtime   t0 = 0.0, t1 = 0.0;

   always @(posedge m_clk or negedge rst_n) begin
      if (!rst_n) begin
         m_bit = 0; m_word = 0; m_run = 0; m_rate = 0; m_shape = 0; m_clkmode = 0;
      end else begin
         chg = (int'(rate_sel) != m_rate) || (word_wide != m_shape) ||
               (int'(clk_src_mode) != m_clkmode);
         m_rate = int'(rate_sel); m_shape = word_wide; m_clkmode = int'(clk_src_mode);
         if (!enable || chg) begin
            m_bit = 0; m_word = 0; m_run = 0;
         end else if (!m_run) begin
            m_run = 1;
         end else begin
            m_bit++;
            if (m_bit == WLEN) begin
               m_bit = 0;
               m_word++;
               if (m_word > m_rate) m_word = 0;
            end
         end
      end
      #1;
      exp_int = m_run && (m_word == 0) && (m_shape || m_bit == 0);
      case (frame_src_mode)
         2'b10:   exp_tx = exp_int;
         2'b11:   exp_tx = io2_pin_in;
         default: exp_tx = rx_fsync;
      endcase
      chk(int_fsync === exp_int, cur_req, "int_fsync", int'(int_fsync), int'(exp_int));
      chk(tx_fsync === exp_tx, "R9", "tx_fsync", int'(tx_fsync), int'(exp_tx));
      chk(io2_drive_en === (frame_src_mode == 2'b10), "R10", "io2_drive_en",
          int'(io2_drive_en), int'(frame_src_mode == 2'b10));
      chk(io2_drive_val === exp_int, "R10", "io2_drive_val", int'(io2_drive_val), int'(exp_int));
      if (meas_left > 0) begin
         if (meas_left == meas_total) t0 = $realtime;
         if (int_fsync && !prev) rises++;
         if (int_fsync) highs++;
         prev = int_fsync;
         meas_left--;
         if (meas_left == 0) t1 = $realtime;
      end
   end

   task automatic meas(int n);
      prev = 0; rises = 0; highs = 0;
      meas_total = n;
      meas_left = n;
      wait (meas_left == 0);
   endtask

   task automatic start(int rate, bit shape, logic [1:0] cmode, int n);
      @(negedge rx_clk);
      enable = 1'b0;
      rate_sel = rate[3:0];
      word_wide = shape;
      clk_src_mode = cmode;
      repeat (4) @(negedge rx_clk);
      enable = 1'b1;
      meas(n);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge rx_clk);
      #1;
      // R2
      chk(int_fsync === 1'b0, "R2", "int_fsync in reset", int'(int_fsync), 0);
      chk(tx_fsync === 1'b0, "R2", "tx_fsync in reset", int'(tx_fsync), 0);
      @(negedge rx_clk);
      rst_n = 1'b1;

      // R3: disabled generation stays low
      cur_req = "R3";
      rate_sel = 4'd3;
      repeat (40) @(negedge rx_clk);
      #1 chk(int_fsync === 1'b0, "R3", "int_fsync disabled", int'(int_fsync), 0);

      // R4, R5: one-bit strobe, frames of 4 words
      cur_req = "R5";
      start(3, 1'b0, 2'b00, 128);
      chk(rises == 2, "R5", "rises bit mode rate 3", rises, 2);
      chk(highs == 2, "R5", "high periods bit mode rate 3", highs, 2);

      // R6: word-wide strobe, frames of 2 words
      cur_req = "R6";
      start(1, 1'b1, 2'b00, 64);
      chk(rises == 2, "R6", "rises word mode rate 1", rises, 2);
      chk(highs == 32, "R6", "high periods word mode rate 1", highs, 32);

      // R7: a frame every word, on the receive clock
      cur_req = "R7";
      start(0, 1'b0, 2'b00, 64);
      chk(rises == 4, "R7", "rises rate 0", rises, 4);
      chk(highs == 4, "R7", "high periods rate 0", highs, 4);
      chk((t1 - t0) > 251.9 && (t1 - t0) < 252.1, "R1", "rx span ns",
          int'(t1 - t0), 252);

      // R8: rate change while running restarts the frame
      cur_req = "R8";
      @(negedge rx_clk);
      rate_sel = 4'd1;
      meas(34);
      chk(highs == 2, "R8", "high periods after rate change", highs, 2);
      chk(rises == 2, "R8", "rises after rate change", rises, 2);
      // R8: shape change while running
      @(negedge rx_clk);
      word_wide = 1'b1;
      meas(20);
      chk(highs == 16, "R8", "high periods after shape change", highs, 16);
      chk(rises == 1, "R8", "rises after shape change", rises, 1);

      // R9, R10: framing source selection under all modes
      cur_req = "R9";
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 4; p++) begin
            @(negedge rx_clk);
            frame_src_mode = m[1:0];
            rx_fsync = p[0];
            io2_pin_in = p[1];
            #1;
            chk(tx_fsync === ((m == 2) ? int_fsync : (m == 3) ? p[1] : p[0]),
                "R9", "tx_fsync select", int'(tx_fsync),
                int'((m == 2) ? int_fsync : (m == 3) ? p[1] : p[0]));
            chk(io2_drive_en === (m == 2), "R10", "io2_drive_en", int'(io2_drive_en),
                int'(m == 2));
         end
      end
      frame_src_mode = 2'b10;

      // R1: transmit clock pin as bit clock
      cur_req = "R1";
      start(0, 1'b0, 2'b10, 64);
      chk(rises == 4, "R1", "rises on tx clock", rises, 4);
      chk((t1 - t0) > 377.9 && (t1 - t0) < 378.1, "R1", "tx span ns",
          int'(t1 - t0), 378);

      @(negedge rx_clk);
      enable = 1'b0;
      repeat (4) @(negedge rx_clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule